// File: doc/BRIEF.md
# Mixed-Policy Direct-Mapped Data Cache Controller

This block sits between a processor load/store port and a memory port that moves one word per beat. It keeps a small direct-mapped store of lines. Each line holds four 32-bit words, an address tag, a valid flag and a modified flag. Every processor request carries a policy flag for its address region, so copyback and write-through traffic can share one cache.

Read misses fill the whole line from memory. Write misses in a copyback region allocate the line, fill it, and then merge the store bytes into it. Write misses in a write-through region go directly to memory and leave the cache untouched. Before a slot holding modified data is refilled, that data is written back to memory. A single control input drops every line at once.

The processor raises a request and holds it until a one-cycle completion pulse. On the memory side, each beat is one word under a valid/ready handshake.

Top module: `mpc_cache_ctrl`

## Requirements
- R1: After reset `cpu_done` and `mem_valid` are low and every line is invalid, so the first access to any address misses.
- R2: A line is invalid (V=0, M=0), clean (V=1, M=0) or modified (V=1, M=1). M is never set while V is clear.
- R3: A read miss issues exactly four memory read beats, at word offsets 0, 1, 2 and 3 of the line base in that order. It then completes with the requested word, and the line is installed clean.
- R4: A read hit completes with the cached word, makes no memory beat and leaves V and M unchanged. This holds whatever the request's policy flag (`cpu_cback` = 1 copyback, 0 write-through), so a read hit never pushes modified data out.
- R5: A copyback write miss first fills the line with four read beats and makes no memory write for the store itself. It then changes only the bytes selected by `cpu_be` (bit b covers data bits 8b+7..8b) and sets M.
- R6: A write-through write miss makes exactly one memory write beat, with the word-aligned request address, the request data and `cpu_be`. It allocates no line, so a later read of that line misses.
- R7: A copyback write hit updates the selected bytes in the cache, makes no memory beat and sets M.
- R8: A write-through write hit updates the selected bytes in the cache and makes one memory write beat with the same data and byte enables. M is unchanged.
- R9: A miss that needs a slot holding a modified line first writes all four words of that line to memory, at offsets 0, 1, 2 and 3 of the old line base in ascending order. Only then does the fill start.
- R10: A one-cycle pulse on `inval_all` clears V and M of every line and discards any modified data. The next access to any address misses.
- R11: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_write` hold their values.
- R12: `cpu_done` is a single-cycle pulse, raised once per request, after every memory beat the request needs has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inval_all | input | 1 | Drop every line (V and M cleared) |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_cback | input | 1 | Region policy: 1 copyback, 0 write-through |
| cpu_addr | input | ADDR_W | Byte address; word offset in bits [3:2], line index above |
| cpu_wdata | input | DATA_W | Store data |
| cpu_be | input | DATA_W/8 | Store byte enables |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | DATA_W | Load data, valid with `cpu_done` |
| mem_valid | output | 1 | Memory beat request |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | ADDR_W | Word-aligned beat address |
| mem_wdata | output | DATA_W | Write beat data |
| mem_be | output | DATA_W/8 | Write beat byte enables |
| mem_ready | input | 1 | Memory accepts or returns the beat |
| mem_rdata | input | DATA_W | Read beat data, valid with `mem_ready` |

## Verification
The bench builds the controller with a 10-bit address and only four lines. The memory is then 256 words, and each slot is shared by sixteen tags. With that much aliasing, a few hundred pseudo-random requests reach every combination of hit or miss, clean or modified victim, and read, copyback write or write-through write, many times over. A small reference model of tags and flags in the bench predicts the exact number and addresses of memory beats for each request, alongside a golden memory image for load data. Random wait states on `mem_ready` and periodic invalidate pulses cover stalled beats and dropped modified lines.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WBACK,
      ST_FILL,
      ST_WTHRU,
      ST_DONE
   } mpc_state_t;
endpackage

// File: rtl/mpc_tag_store.sv
module mpc_tag_store #(
   parameter int LINES = 64,
   parameter int TAG_W = 22,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inval,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             install,
   input  logic [TAG_W-1:0] install_tag,
   input  logic             mark_dirty,
   input  logic             mark_clean,
   input  logic [IDX_W-1:0] look_idx,
   output logic             look_valid,
   output logic             look_dirty,
   output logic [TAG_W-1:0] look_tag
);
   logic [LINES-1:0] valid_q;
   logic [LINES-1:0] dirty_q;
   logic [TAG_W-1:0] tag_q [LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         dirty_q <= '0;
      end else begin
         for (int i = 0; i < LINES; i++) begin
            if (inval) begin
               valid_q[i] <= 1'b0;
               dirty_q[i] <= 1'b0;
            end else if (upd_idx == IDX_W'(i)) begin
               if (install) begin
                  valid_q[i] <= 1'b1;
                  dirty_q[i] <= 1'b0;
               end else if (mark_clean) begin
                  dirty_q[i] <= 1'b0;
               end else if (mark_dirty) begin
                  dirty_q[i] <= 1'b1;
               end
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (install) tag_q[upd_idx] <= install_tag;
   end

   assign look_valid = valid_q[look_idx];
   assign look_dirty = dirty_q[look_idx];
   assign look_tag   = tag_q[look_idx];

   // R2: a modified line is always a valid line
   p_dirty_implies_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (dirty_q & ~valid_q) == '0);
endmodule

// File: rtl/mpc_data_store.sv
module mpc_data_store #(
   parameter int DEPTH  = 256,
   parameter int DATA_W = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int BE_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [BE_W-1:0]   wbe,
   input  logic [AW-1:0]     raddr,
   output logic [DATA_W-1:0] rdata
);
   for (genvar b = 0; b < BE_W; b++) begin : g_lane
      logic [7:0] lane_q [DEPTH];
      always_ff @(posedge clk) begin
         if (we && wbe[b]) lane_q[waddr] <= wdata[8*b +: 8];
      end
      assign rdata[8*b +: 8] = lane_q[raddr];
   end
endmodule

// File: rtl/mpc_cache_ctrl.sv
module mpc_cache_ctrl
   import mpc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 64,
   parameter int LINE_WORDS = 4,
   localparam int BE_W   = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inval_all,
   input  logic              cpu_req,
   input  logic              cpu_write,
   input  logic              cpu_cback,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic [BE_W-1:0]   cpu_be,
   output logic              cpu_done,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [BE_W-1:0]   mem_be,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int BOFF_W = $clog2(BE_W);
   localparam int WOFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int TAG_W  = ADDR_W - IDX_W - WOFF_W - BOFF_W;
   localparam int DEPTH  = LINES * LINE_WORDS;

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 8");
   end
   if (LINES < 2 || (LINES & (LINES - 1)) != 0) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (LINE_WORDS < 2 || (LINE_WORDS & (LINE_WORDS - 1)) != 0) begin : g_bad_words
      $error("LINE_WORDS must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W too small for the chosen geometry");
   end

   mpc_state_t         state_q, state_d;
   logic [WOFF_W-1:0]  beat_q, beat_d;
   logic [DATA_W-1:0]  rdata_q;

   logic [WOFF_W-1:0]  req_woff;
   logic [IDX_W-1:0]   req_idx;
   logic [TAG_W-1:0]   req_tag;
   logic               lk_valid, lk_dirty, hit, xfer, last_beat;
   logic [TAG_W-1:0]   lk_tag;

   logic               ds_we, rd_load, inst_en, dset, dclr;
   logic [WOFF_W-1:0]  ds_woff;
   logic [DATA_W-1:0]  ds_wdata, ds_rdata;
   logic [BE_W-1:0]    ds_wbe;

   assign req_woff  = cpu_addr[BOFF_W +: WOFF_W];
   assign req_idx   = cpu_addr[BOFF_W + WOFF_W +: IDX_W];
   assign req_tag   = cpu_addr[ADDR_W-1 -: TAG_W];
   assign hit       = lk_valid && (lk_tag == req_tag);
   assign xfer      = mem_valid && mem_ready;
   assign last_beat = (beat_q == WOFF_W'(LINE_WORDS - 1));

   mpc_tag_store #(.LINES(LINES), .TAG_W(TAG_W)) u_tags (
      .clk         (clk),
      .rst_n       (rst_n),
      .inval       (inval_all),
      .upd_idx     (req_idx),
      .install     (inst_en),
      .install_tag (req_tag),
      .mark_dirty  (dset),
      .mark_clean  (dclr),
      .look_idx    (req_idx),
      .look_valid  (lk_valid),
      .look_dirty  (lk_dirty),
      .look_tag    (lk_tag)
   );

   mpc_data_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_data (
      .clk   (clk),
      .we    (ds_we),
      .waddr ({req_idx, ds_woff}),
      .wdata (ds_wdata),
      .wbe   (ds_wbe),
      .raddr ({req_idx, (state_q == ST_WBACK) ? beat_q : req_woff}),
      .rdata (ds_rdata)
   );

   always_comb begin
      state_d  = state_q;
      beat_d   = beat_q;
      ds_we    = 1'b0;
      ds_woff  = req_woff;
      ds_wdata = cpu_wdata;
      ds_wbe   = cpu_be;
      inst_en  = 1'b0;
      dset     = 1'b0;
      dclr     = 1'b0;
      rd_load  = 1'b0;
      unique case (state_q)
         ST_IDLE: if (cpu_req) begin
            if (hit) begin
               if (!cpu_write) begin
                  rd_load = 1'b1;
                  state_d = ST_DONE;
               end else begin
                  ds_we = 1'b1;
                  if (cpu_cback) begin
                     dset    = 1'b1;
                     state_d = ST_DONE;
                  end else begin
                     state_d = ST_WTHRU;
                  end
               end
            end else if (cpu_write && !cpu_cback) begin
               state_d = ST_WTHRU;
            end else begin
               beat_d  = '0;
               state_d = (lk_valid && lk_dirty) ? ST_WBACK : ST_FILL;
            end
         end
         ST_WBACK: if (xfer) begin
            beat_d = beat_q + 1'b1;
            if (last_beat) begin
               dclr    = 1'b1;
               state_d = ST_FILL;
            end
         end
         ST_FILL: if (xfer) begin
            ds_we    = 1'b1;
            ds_woff  = beat_q;
            ds_wdata = mem_rdata;
            ds_wbe   = '1;
            beat_d   = beat_q + 1'b1;
            if (last_beat) begin
               inst_en = 1'b1;
               state_d = ST_IDLE;
            end
         end
         ST_WTHRU: if (xfer) state_d = ST_DONE;
         ST_DONE:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
         rdata_q <= '0;
      end else begin
         state_q <= state_d;
         beat_q  <= beat_d;
         if (rd_load) rdata_q <= ds_rdata;
      end
   end

   assign cpu_done  = (state_q == ST_DONE);
   assign cpu_rdata = rdata_q;
   assign mem_valid = (state_q == ST_WBACK) || (state_q == ST_FILL) || (state_q == ST_WTHRU);
   assign mem_write = (state_q == ST_WBACK) || (state_q == ST_WTHRU);
   assign mem_wdata = (state_q == ST_WBACK) ? ds_rdata : cpu_wdata;
   assign mem_be    = (state_q == ST_WTHRU) ? cpu_be : '1;

   always_comb begin
      unique case (state_q)
         ST_WBACK: mem_addr = {lk_tag, req_idx, beat_q, {BOFF_W{1'b0}}};
         ST_FILL:  mem_addr = {req_tag, req_idx, beat_q, {BOFF_W{1'b0}}};
         default:  mem_addr = {cpu_addr[ADDR_W-1:BOFF_W], {BOFF_W{1'b0}}};
      endcase
   end

   // R12: completion lasts one cycle
   p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |=> !cpu_done);

   // R11: a stalled beat holds its request
   p_beat_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

   // R9: a fill never starts over a modified victim
   p_fill_clean_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL && $past(state_q) != ST_FILL) |-> !(lk_valid && lk_dirty));

   // R9: writeback beats climb one word at a time
   p_wb_ascending_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WBACK && $past(state_q) == ST_WBACK && $past(xfer))
      |-> mem_addr == $past(mem_addr) + ADDR_W'(BE_W));

   // R6: a write-through store never allocates
   p_wt_no_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inst_en |-> !(cpu_write && !cpu_cback));
endmodule

// File: tb/mpc_cache_ctrl_tb.sv
`timescale 1ns/1ps
module mpc_cache_ctrl_tb;
   localparam int AW = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inval_all = 1'b0;
   logic        cpu_req = 1'b0, cpu_write = 1'b0, cpu_cback = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [31:0] cpu_wdata = '0;
   logic [3:0]  cpu_be = '0;
   logic        cpu_done;
   logic [31:0] cpu_rdata;
   logic        mem_valid, mem_write, mem_ready;
   logic [AW-1:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic [3:0]  mem_be;

   always #4 clk = ~clk;

   mpc_cache_ctrl #(.ADDR_W(AW), .DATA_W(32), .LINES(4), .LINE_WORDS(4)) u_dut (
      .clk(clk), .rst_n(rst_n), .inval_all(inval_all),
      .cpu_req(cpu_req), .cpu_write(cpu_write), .cpu_cback(cpu_cback),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_be(cpu_be),
      .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
      .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ready(mem_ready),
      .mem_rdata(mem_rdata)
   );

   function automatic logic [31:0] init_word(input int i);
      return {i[7:0], ~i[7:0], 8'h5A, i[7:0] ^ 8'h3C};
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                         input logic [3:0] be);
      logic [31:0] r;
      r = o;
      for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
      return r;
   endfunction

   // memory model: beats are recorded at the falling edge before the accepting rise
   logic [31:0] bmem [256];
   logic [31:0] golden [256];
   int          rd_cnt = 0, wr_cnt = 0, hold_err = 0;
   logic [AW-1:0] rd_log [16];
   logic [AW-1:0] wr_log [16];
   logic [3:0]  wr_be_log [16];
   logic        prev_pend = 1'b0;
   logic [AW-1:0] prev_addr = '0;
   logic        prev_wr = 1'b0;
   logic [7:0]  lfsr = 8'h5B;

   assign mem_rdata = bmem[mem_addr[9:2]];

   always @(negedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) bmem[i] = init_word(i);
         prev_pend = 1'b0;
      end else begin
         if (prev_pend && (mem_valid !== 1'b1 || mem_addr != prev_addr || mem_write != prev_wr))
            hold_err++;
         prev_pend = mem_valid && !mem_ready;
         prev_addr = mem_addr;
         prev_wr   = mem_write;
         if (mem_valid && mem_ready) begin
            if (mem_write) begin
               bmem[mem_addr[9:2]] = merge(bmem[mem_addr[9:2]], mem_wdata, mem_be);
               wr_log[wr_cnt % 16] = mem_addr;
               wr_be_log[wr_cnt % 16] = mem_be;
               wr_cnt++;
            end else begin
               rd_log[rd_cnt % 16] = mem_addr;
               rd_cnt++;
            end
         end
      end
   end

   always @(posedge clk) begin
      lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready <= lfsr[0] | lfsr[2];
   end

   int checks = 0, fails = 0;
   int cycles = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         check(1'b0, "watchdog", cycles, 150000);
         finish_run();
      end
   end

   // reference model of the cache flags
   logic       mv [4];
   logic       md [4];
   logic [3:0] mt [4];
   int last_nrd, last_nwr;

   task automatic do_op(input logic wr, input logic cb, input logic [AW-1:0] addr,
                        input logic [31:0] wd, input logic [3:0] be);
      int idx, n, rs, ws, exp_rd, exp_wr;
      logic [3:0] tg;
      logic [7:0] w;
      logic hit, vdirty, aok;
      logic [31:0] rd;
      string lab;
      idx = int'(addr[5:4]);
      tg  = addr[9:6];
      w   = addr[9:2];
      hit = mv[idx] && mt[idx] == tg;
      vdirty = mv[idx] && md[idx] && !hit;
      rs = rd_cnt; ws = wr_cnt;
      @(negedge clk);
      cpu_req = 1'b1; cpu_write = wr; cpu_cback = cb; cpu_addr = addr;
      cpu_wdata = wd; cpu_be = be;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cpu_done && n < 600);
      rd = cpu_rdata;
      cpu_req = 1'b0;
      check(n < 600, "R12 completion", n, 600);
      last_nrd = rd_cnt - rs;
      last_nwr = wr_cnt - ws;
      // expected traffic from the requirements
      if (wr && !cb) begin
         exp_rd = 0; exp_wr = 1; lab = hit ? "R8" : "R6";
      end else begin
         exp_rd = hit ? 0 : 4;
         exp_wr = vdirty ? 4 : 0;
         if (vdirty) lab = "R2/R9";
         else if (hit) lab = wr ? "R7" : "R4";
         else lab = wr ? "R5" : "R3";
      end
      check(last_nrd == exp_rd && last_nwr == exp_wr, lab,
            {last_nrd[15:0], last_nwr[15:0]}, {exp_rd[15:0], exp_wr[15:0]});
      aok = 1'b1;
      if (exp_rd == 4 && last_nrd == 4)
         for (int k = 0; k < 4; k++)
            if (rd_log[(rs + k) % 16] != {tg, addr[5:4], k[1:0], 2'b00}) aok = 1'b0;
      if (exp_wr == 4 && last_nwr == 4)
         for (int k = 0; k < 4; k++)
            if (wr_log[(ws + k) % 16] != {mt[idx], addr[5:4], k[1:0], 2'b00}) aok = 1'b0;
      if (exp_wr == 1 && last_nwr == 1)
         if (wr_log[ws % 16] != {addr[9:2], 2'b00} || wr_be_log[ws % 16] != be) aok = 1'b0;
      check(aok, {lab, " beat addresses"}, {22'd0, addr}, 32'd0);
      if (!wr) check(rd == golden[w], hit ? "R4 data" : "R3 data", rd, golden[w]);
      // model update
      if (wr) golden[w] = merge(golden[w], wd, be);
      if (wr && !cb) begin
         if (!(hit && md[idx]))
            check(bmem[w] == golden[w], lab, bmem[w], golden[w]);
      end else begin
         if (!hit) begin mv[idx] = 1'b1; mt[idx] = tg; md[idx] = 1'b0; end
         if (wr) md[idx] = 1'b1;
      end
      @(negedge clk);
      check(cpu_done == 1'b0, "R12 single pulse", cpu_done, 0);
   endtask

   task automatic do_inval();
      @(negedge clk);
      inval_all = 1'b1;
      @(negedge clk);
      inval_all = 1'b0;
      for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = 1'b0; end
      for (int i = 0; i < 256; i++) golden[i] = bmem[i];
   endtask

   logic [31:0] seed = 32'h1234_5678;

   initial begin
      for (int i = 0; i < 256; i++) golden[i] = init_word(i);
      for (int i = 0; i < 4; i++) begin mv[i] = 1'b0; md[i] = 1'b0; mt[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cpu_done == 1'b0, "R1 done low", cpu_done, 0);
      check(mem_valid == 1'b0, "R1 mem idle", mem_valid, 0);
      do_op(1'b0, 1'b1, 10'h000, 0, 0);
      check(last_nrd == 4, "R1 first access misses", last_nrd, 4);
      do_op(1'b0, 1'b1, 10'h004, 0, 0);                 // R4 hit
      do_op(1'b1, 1'b1, 10'h04B, 32'hEE00_0000, 4'b1000); // R5 allocate and merge
      do_op(1'b0, 1'b1, 10'h048, 0, 0);                 // R5 merged word
      do_op(1'b0, 1'b0, 10'h048, 0, 0);                 // R4 policy flag changed
      do_op(1'b0, 1'b1, 10'h008, 0, 0);                 // R9 dirty eviction
      do_op(1'b1, 1'b0, 10'h104, 32'hCAFE_F00D, 4'b0011); // R6 bypass
      do_op(1'b0, 1'b1, 10'h104, 0, 0);                 // R6 line was not allocated
      do_op(1'b1, 1'b0, 10'h108, 32'h1111_2222, 4'b1111); // R8
      do_op(1'b1, 1'b1, 10'h100, 32'h3333_4444, 4'b0110); // R7
      do_inval();
      do_op(1'b0, 1'b1, 10'h100, 0, 0);
      check(last_nrd == 4 && last_nwr == 0, "R10 all lines dropped",
            {last_nrd[15:0], last_nwr[15:0]}, {16'd4, 16'd0});
      for (int i = 0; i < 450; i++) begin
         logic [3:0] be;
         seed = seed * 32'd1664525 + 32'd1013904223;
         be = seed[3:0] == 0 ? 4'b0001 : seed[3:0];
         do_op(seed[20], seed[21], seed[31:22], {seed[15:0], ~seed[15:0]}, be);
         if (i % 70 == 69) do_inval();
      end
      check(hold_err == 0, "R11 stalled beat held", hold_err, 0);
      finish_run();
   end
endmodule